// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a physical address for a memory management unit that has no translation cache. Each request carries an access kind (read, write or instruction fetch) and a privilege flag. The block reads one or two translation descriptors from memory through a simple read port. It then returns a physical address with the read and write rights that apply, or a fault status word. Every request makes a complete walk, and only one walk is in flight at a time.

The walker supports 1 MB sections and 64 KB, 4 KB and 1 KB pages. Each descriptor names one of sixteen domains, and a per-domain field can block access or bypass the page rights. Addresses in the low 32 MB are moved by a per-process offset before translation. A faulting walk also loads the instruction-side or data-side fault status and address registers, depending on the access kind. The translation base, domain rights, control word and process offset are plain inputs that are held steady while a walk is running.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only when idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the result is given. `rsp_valid` is a one-cycle pulse, and `req_ready` is high again in the cycle after it.
- R2: A virtual address below `RELOC_LIMIT` (default 0x0200_0000) has `cfg_pid` added to it before any use. An address equal to or above the limit is used unchanged.
- R3: When `cfg_ctrl[0]` is 0, no memory read is made. The result is the relocated address, with `rsp_rd` = `rsp_wr` = 1 and no fault.
- R4: The first descriptor is read from {`cfg_ttb[31:14]`, VA[31:20], 2'b00}. Its bits [1:0] give the kind: 0 is a fault with code 5, 2 is a section, and 1 or 3 are page tables.
- R5: The domain number is descriptor bits [8:5], and its rights field is `cfg_dacr[2n+1:2n]`. Field 0 or 2 is a fault, with code 9 for a section or 11 for a page table, and no second read is made.
- R6: A section gives PA = {desc[31:20], VA[19:0]}, and its permission field is desc[11:10].
- R7: The second descriptor is read from {desc1[31:10], VA[19:12], 2'b00}. Its kind 0 is a fault with code 7. Kind 1 gives PA {d[31:16],VA[15:0]}. Kind 2 gives {d[31:12],VA[11:0]}. Kind 3 gives {d[31:10],VA[9:0]}, but it is a fault with code 7 when the first kind was 1.
- R8: For 64 KB and 4 KB pages, the permission field is d[5+2k:4+2k] with k = VA[15:14]. For 1 KB pages it is d[5:4].
- R9: Access kinds are 0 read, 1 write and 2 fetch, and `req_priv`=1 means privileged. Rights field 3 grants read and write. Otherwise the permission field decides. 1 gives read and write to privileged accesses only. 2 gives privileged read and write, and user read only. 3 gives read and write to all. 0 refuses writes. For reads and fetches with field 0, `cfg_ctrl[9:8]` decides: 1 allows privileged read, 2 allows read for all, and any other value allows nothing.
- R10: An access that is refused is a fault with code 13 for a section or 15 for a page. `rsp_fsr` = {domain number, code}. On any fault `rsp_rd` = `rsp_wr` = 0.
- R11: A fetch fault loads `ifsr`/`ifar`. Any other fault loads `dfsr`/`dfar`. The address stored is the VA as requested. A walk that succeeds leaves all four unchanged, and all four are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request taken |
| req_va | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Privileged access |
| cfg_ctrl | input | 32 | Control word: bit 0 enables translation, bits 9:8 set the field-0 read policy |
| cfg_ttb | input | 32 | First-level table base |
| cfg_dacr | input | 32 | Sixteen 2-bit domain rights fields |
| cfg_pid | input | 32 | Low-address relocation offset |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Walk faulted |
| rsp_pa | output | 32 | Physical address |
| rsp_rd | output | 1 | Read granted |
| rsp_wr | output | 1 | Write granted |
| rsp_fsr | output | 8 | Fault status {domain, code} |
| ifsr | output | 8 | Instruction fault status |
| ifar | output | 32 | Instruction fault address |
| dfsr | output | 8 | Data fault status |
| dfar | output | 32 | Data fault address |

## Verification
The bench builds the walker with `RELOC_LIMIT` left at 0x0200_0000. This puts the relocation boundary at an address that also indexes an ordinary first-level entry, so the bench can compare the address just below the limit with the address exactly on it. Its memory model toggles the read-ready every cycle, so descriptor reads meet both an immediate accept and a stall. The domain word gives domains 0 to 4 the rights fields 1, 3, 0, 2 and 1. This makes client, manager and both blocking values reachable, together with a non-zero domain number in a permission fault.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W   = 32;
  localparam int DOM_W  = 4;
  localparam int CODE_W = 4;
  localparam int FSR_W  = DOM_W + CODE_W;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_CHECK,
    ST_DONE
  } walk_st_t;

  localparam logic [CODE_W-1:0] FC_L1_XLAT  = 4'd5;
  localparam logic [CODE_W-1:0] FC_L2_XLAT  = 4'd7;
  localparam logic [CODE_W-1:0] FC_SEC_DOM  = 4'd9;
  localparam logic [CODE_W-1:0] FC_PG_DOM   = 4'd11;
  localparam logic [CODE_W-1:0] FC_SEC_PERM = 4'd13;
  localparam logic [CODE_W-1:0] FC_PG_PERM  = 4'd15;
endpackage

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [VA_W-1:0] desc,
  input  logic [15:0]     va_lo,
  input  logic [1:0]      l1_kind,
  output logic [VA_W-1:0] pa,
  output logic [1:0]      ap,
  output logic            bad
);
  logic [1:0] sub_ap;
  logic       unused_cb;

  assign unused_cb = ^desc[3:2];

  // R8: a large or small page splits into four quarters, and each quarter has its own permission field
  always_comb begin
    case (va_lo[15:14])
      2'd0:    sub_ap = desc[5:4];
      2'd1:    sub_ap = desc[7:6];
      2'd2:    sub_ap = desc[9:8];
      default: sub_ap = desc[11:10];
    endcase
  end

  // R7: second-level kinds
  always_comb begin
    bad = 1'b0;
    pa  = '0;
    ap  = sub_ap;
    case (desc[1:0])
      2'd0: bad = 1'b1;
      2'd1: pa  = {desc[31:16], va_lo[15:0]};
      2'd2: pa  = {desc[31:12], va_lo[11:0]};
      default: begin
        pa  = {desc[31:10], va_lo[9:0]};
        ap  = desc[5:4];
        bad = (l1_kind == 2'd1);
      end
    endcase
  end
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [1:0] dfield,
  input  logic [1:0] ap,
  input  logic [1:0] acc,
  input  logic       priv,
  input  logic [1:0] rd_policy,
  output logic       grant_rd,
  output logic       grant_wr
);
  // R9: the domain field bypasses the permission field, then the permission field is decoded
  always_comb begin
    grant_rd = 1'b0;
    grant_wr = 1'b0;
    if (dfield == 2'd3) begin
      grant_rd = 1'b1;
      grant_wr = 1'b1;
    end else begin
      case (ap)
        2'd0: begin
          if (acc != ACC_WRITE) begin
            case (rd_policy)
              2'd1:    grant_rd = priv;
              2'd2:    grant_rd = 1'b1;
              default: grant_rd = 1'b0;
            endcase
          end
        end
        2'd1: begin
          grant_rd = priv;
          grant_wr = priv;
        end
        2'd2: begin
          grant_rd = priv || (acc != ACC_WRITE);
          grant_wr = priv;
        end
        default: begin
          grant_rd = 1'b1;
          grant_wr = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter logic [31:0] RELOC_LIMIT = 32'h0200_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic [1:0]  req_acc,
  input  logic        req_priv,
  input  logic [31:0] cfg_ctrl,
  input  logic [31:0] cfg_ttb,
  input  logic [31:0] cfg_dacr,
  input  logic [31:0] cfg_pid,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic        rsp_fault,
  output logic [31:0] rsp_pa,
  output logic        rsp_rd,
  output logic        rsp_wr,
  output logic [7:0]  rsp_fsr,
  output logic [7:0]  ifsr,
  output logic [31:0] ifar,
  output logic [7:0]  dfsr,
  output logic [31:0] dfar
);
  walk_st_t           st_q, st_d;
  logic               iss_q, iss_d;
  logic [VA_W-1:0]    va_q, eff_q, d1_q, cpa_q, cpa_d;
  logic [1:0]         acc_q, cap_q, cap_d;
  logic               priv_q, pg_q, pg_d;
  logic               accept, ld_d1, ld_chk, go_done;
  logic               nx_fault, nx_rd, nx_wr;
  logic [CODE_W-1:0]  nx_code;
  logic [VA_W-1:0]    nx_pa, eff_in, dsrc;
  logic [DOM_W-1:0]   dom;
  logic [1:0]         dfield;
  logic               rsp_hit;
  logic [VA_W-1:0]    l2_pa;
  logic [1:0]         l2_ap;
  logic               l2_bad;
  logic               p_rd, p_wr;
  logic               unused_cfg;

  assign unused_cfg = ^{cfg_ctrl[31:10], cfg_ctrl[7:1], cfg_ttb[13:0], d1_q[9], d1_q[4:2]};

  // R2: low-address relocation
  assign eff_in    = (req_va < RELOC_LIMIT) ? (req_va + cfg_pid) : req_va;
  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rsp_valid = (st_q == ST_DONE);
  assign rsp_hit   = iss_q && mem_rsp_valid;

  assign dsrc   = (st_q == ST_L1) ? mem_rsp_data : d1_q;
  assign dom    = dsrc[8:5];
  assign dfield = cfg_dacr[{dom, 1'b0} +: 2];

  // R4, R7: descriptor addresses
  assign mem_req_valid = ((st_q == ST_L1) || (st_q == ST_L2)) && !iss_q;
  assign mem_req_addr  = (st_q == ST_L1) ? {cfg_ttb[31:14], eff_q[31:20], 2'b00}
                                         : {d1_q[31:10], eff_q[19:12], 2'b00};

  ptw_l2_decode u_l2 (
    .desc    (mem_rsp_data),
    .va_lo   (eff_q[15:0]),
    .l1_kind (d1_q[1:0]),
    .pa      (l2_pa),
    .ap      (l2_ap),
    .bad     (l2_bad)
  );

  ptw_perm u_perm (
    .dfield    (dfield),
    .ap        (cap_q),
    .acc       (acc_q),
    .priv      (priv_q),
    .rd_policy (cfg_ctrl[9:8]),
    .grant_rd  (p_rd),
    .grant_wr  (p_wr)
  );

  always_comb begin
    st_d     = st_q;
    iss_d    = iss_q;
    ld_d1    = 1'b0;
    ld_chk   = 1'b0;
    cpa_d    = cpa_q;
    cap_d    = cap_q;
    pg_d     = pg_q;
    go_done  = 1'b0;
    nx_fault = 1'b0;
    nx_code  = '0;
    nx_pa    = '0;
    nx_rd    = 1'b0;
    nx_wr    = 1'b0;
    if (mem_req_valid && mem_req_ready) iss_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          iss_d = 1'b0;
          if (!cfg_ctrl[0]) begin
            go_done = 1'b1;
            nx_pa   = eff_in;
            nx_rd   = 1'b1;
            nx_wr   = 1'b1;
          end else begin
            st_d = ST_L1;
          end
        end
      end
      ST_L1: begin
        if (rsp_hit) begin
          ld_d1 = 1'b1;
          if (mem_rsp_data[1:0] == 2'd0) begin
            go_done  = 1'b1;
            nx_fault = 1'b1;
            nx_code  = FC_L1_XLAT;
          end else if (!dfield[0]) begin
            go_done  = 1'b1;
            nx_fault = 1'b1;
            nx_code  = (mem_rsp_data[1:0] == 2'd2) ? FC_SEC_DOM : FC_PG_DOM;
          end else if (mem_rsp_data[1:0] == 2'd2) begin
            ld_chk = 1'b1;
            cpa_d  = {mem_rsp_data[31:20], eff_q[19:0]};
            cap_d  = mem_rsp_data[11:10];
            pg_d   = 1'b0;
            st_d   = ST_CHECK;
          end else begin
            iss_d = 1'b0;
            st_d  = ST_L2;
          end
        end
      end
      ST_L2: begin
        if (rsp_hit) begin
          if (l2_bad) begin
            go_done  = 1'b1;
            nx_fault = 1'b1;
            nx_code  = FC_L2_XLAT;
          end else begin
            ld_chk = 1'b1;
            cpa_d  = l2_pa;
            cap_d  = l2_ap;
            pg_d   = 1'b1;
            st_d   = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        go_done = 1'b1;
        if (!p_rd) begin
          nx_fault = 1'b1;
          nx_code  = pg_q ? FC_PG_PERM : FC_SEC_PERM;
        end else begin
          nx_pa = cpa_q;
          nx_rd = p_rd;
          nx_wr = p_wr;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (go_done) st_d = ST_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      iss_q     <= 1'b0;
      va_q      <= '0;
      eff_q     <= '0;
      acc_q     <= '0;
      priv_q    <= 1'b0;
      d1_q      <= '0;
      cpa_q     <= '0;
      cap_q     <= '0;
      pg_q      <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_pa    <= '0;
      rsp_rd    <= 1'b0;
      rsp_wr    <= 1'b0;
      rsp_fsr   <= '0;
      ifsr      <= '0;
      ifar      <= '0;
      dfsr      <= '0;
      dfar      <= '0;
    end else begin
      st_q  <= st_d;
      iss_q <= iss_d;
      if (accept) begin
        va_q   <= req_va;
        eff_q  <= eff_in;
        acc_q  <= req_acc;
        priv_q <= req_priv;
      end
      if (ld_d1) d1_q <= mem_rsp_data;
      if (ld_chk) begin
        cpa_q <= cpa_d;
        cap_q <= cap_d;
        pg_q  <= pg_d;
      end
      if (go_done) begin
        rsp_fault <= nx_fault;
        rsp_pa    <= nx_pa;
        rsp_rd    <= nx_rd;
        rsp_wr    <= nx_wr;
        rsp_fsr   <= nx_fault ? {dom, nx_code} : '0;
      end
      // R11: fault register steering
      if (go_done && nx_fault) begin
        if (acc_q == ACC_FETCH) begin
          ifsr <= {dom, nx_code};
          ifar <= va_q;
        end else begin
          dfsr <= {dom, nx_code};
          dfar <= va_q;
        end
      end
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready);

  a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  a_r3_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> cfg_ctrl[0]);

  a_r9_grant_reads: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_rd);

  a_r10_fault_denies: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !rsp_rd && !rsp_wr && rsp_fsr[0]);

  a_r11_ifault_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ifsr) || !$stable(ifar) |-> rsp_valid && rsp_fault);

  a_r11_dfault_regs: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dfsr) || !$stable(dfar) |-> rsp_valid && rsp_fault);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  import ptw_pkg::*;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_priv;
  logic [31:0] req_va;
  logic [1:0]  req_acc;
  logic [31:0] cfg_ctrl, cfg_ttb, cfg_dacr, cfg_pid;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_rsp_data;
  logic        rsp_valid, rsp_fault, rsp_rd, rsp_wr;
  logic [31:0] rsp_pa, ifar, dfar;
  logic [7:0]  rsp_fsr, ifsr, dfsr;

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_acc(req_acc), .req_priv(req_priv),
    .cfg_ctrl(cfg_ctrl), .cfg_ttb(cfg_ttb), .cfg_dacr(cfg_dacr), .cfg_pid(cfg_pid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
    .rsp_rd(rsp_rd), .rsp_wr(rsp_wr), .rsp_fsr(rsp_fsr),
    .ifsr(ifsr), .ifar(ifar), .dfsr(dfsr), .dfar(dfar)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // descriptor memory: two entries plus a reads log
  logic [31:0] m_a1, m_d1, m_a2, m_d2;
  logic [31:0] last_addr, prev_addr;
  int          n_reads;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      last_addr     <= '0;
      prev_addr     <= '0;
      n_reads       <= 0;
    end else begin
      mem_req_ready <= ~mem_req_ready;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= (mem_req_addr == m_a1) ? m_d1 :
                         (mem_req_addr == m_a2) ? m_d2 : 32'hDEAD_0000;
        prev_addr     <= last_addr;
        last_addr     <= mem_req_addr;
        n_reads       <= n_reads + 1;
      end
    end
  end

  logic        g_fault, g_rd, g_wr;
  logic [31:0] g_pa;
  logic [7:0]  g_fsr;
  int          g_reads;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic setmem(input logic [31:0] a1, d1, a2, d2);
    m_a1 = a1; m_d1 = d1; m_a2 = a2; m_d2 = d2;
  endtask

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic priv);
    int start;
    int guard;
    start = n_reads;
    @(negedge clk);
    req_va = va; req_acc = acc; req_priv = priv; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 busy after accept", {31'd0, req_ready}, 32'd0);
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    chk("R1 result arrives", {31'd0, rsp_valid}, 32'd1);
    g_fault = rsp_fault; g_pa = rsp_pa; g_rd = rsp_rd; g_wr = rsp_wr; g_fsr = rsp_fsr;
    g_reads = n_reads - start;
    @(negedge clk);
    chk("R1 pulse ends and ready", {30'd0, rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic expect_ok(input string req, input logic [31:0] pa, input logic rd, input logic wr);
    chk(req, {29'd0, g_fault, g_rd, g_wr}, {29'd0, 1'b0, rd, wr});
    chk(req, g_pa, pa);
  endtask

  task automatic expect_fault(input string req, input logic [7:0] fsr);
    chk(req, {23'd0, g_fault, g_fsr}, {23'd0, 1'b1, fsr});
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {30'd0, req_ready, rsp_valid}, 32'd2);
    chk("R11 reset ifsr/dfsr", {16'd0, ifsr, dfsr}, 32'd0);
    chk("R11 reset ifar", ifar, 32'd0);
    chk("R11 reset dfar", dfar, 32'd0);
  endtask

  task automatic t_mmu_off;
    cfg_ctrl = 32'h0; cfg_pid = 32'h0600_0000;
    walk(32'h0040_1234, 2'd1, 1'b0);
    expect_ok("R3 off relocated", 32'h0640_1234, 1'b1, 1'b1);
    chk("R3 no memory read", g_reads, 0);
    walk(32'h8000_0010, 2'd0, 1'b0);
    expect_ok("R2 high address kept", 32'h8000_0010, 1'b1, 1'b1);
    cfg_pid = 32'h0;
  endtask

  task automatic t_section;
    cfg_ctrl = 32'h1;
    setmem(32'h0001_048C, 32'hABC0_0C02, 32'h0, 32'h0);
    walk(32'h1230_0456, 2'd1, 1'b0);
    expect_ok("R6 section pa", 32'hABC0_0456, 1'b1, 1'b1);
    chk("R4 l1 address", last_addr, 32'h0001_048C);
    chk("R4 one read", g_reads, 1);
  endtask

  task automatic t_reloc_on;
    cfg_ctrl = 32'h1; cfg_pid = 32'h0600_0000;
    setmem(32'h0001_0184, 32'hABC0_0C02, 32'h0001_0080, 32'h1110_0C02);
    walk(32'h0010_0ABC, 2'd0, 1'b1);
    expect_ok("R2 relocated walk", 32'hABC0_0ABC, 1'b1, 1'b1);
    chk("R2 relocated index", last_addr, 32'h0001_0184);
    walk(32'h0200_0000, 2'd0, 1'b1);
    expect_ok("R2 limit not relocated", 32'h1110_0000, 1'b1, 1'b1);
    chk("R2 limit index", last_addr, 32'h0001_0080);
    cfg_pid = 32'h0;
  endtask

  task automatic t_l1_faults;
    cfg_ctrl = 32'h1;
    setmem(32'h0001_1158, 32'h0000_0060, 32'h0, 32'h0);
    walk(32'h4560_0000, 2'd0, 1'b1);
    expect_fault("R4 l1 kind 0 code 5", 8'h35);
    chk("R11 dfsr loaded", {24'd0, dfsr}, 32'h35);
    chk("R11 dfar loaded", dfar, 32'h4560_0000);
    chk("R11 ifsr untouched", {24'd0, ifsr}, 32'h0);
    m_d1 = 32'hABC0_0C42;
    walk(32'h4560_0010, 2'd2, 1'b1);
    expect_fault("R5 section domain code 9", 8'h29);
    chk("R11 ifsr loaded", {24'd0, ifsr}, 32'h29);
    chk("R11 ifar loaded", ifar, 32'h4560_0010);
    m_d1 = 32'h0020_0061;
    walk(32'h4560_0020, 2'd0, 1'b1);
    expect_fault("R5 page domain code 11", 8'h3B);
    chk("R5 no second read", g_reads, 1);
    chk("R11 dfsr reloaded", {24'd0, dfsr}, 32'h3B);
  endtask

  task automatic t_4k;
    cfg_ctrl = 32'h1;
    setmem(32'h0001_048C, 32'h0020_0001, 32'h0020_0114, 32'h7777_7082);
    walk(32'h1234_5678, 2'd0, 1'b0);
    expect_ok("R9 4K user read of AP2", 32'h7777_7678, 1'b1, 1'b0);
    chk("R7 l2 address", last_addr, 32'h0020_0114);
    chk("R4 l1 before l2", prev_addr, 32'h0001_048C);
    chk("R7 two reads", g_reads, 2);
    chk("R11 success keeps ifsr/dfsr", {16'd0, ifsr, dfsr}, 32'h293B);
    walk(32'h1234_5678, 2'd1, 1'b0);
    expect_fault("R10 page perm code 15", 8'h0F);
    walk(32'h1234_5678, 2'd1, 1'b1);
    expect_ok("R9 AP2 privileged write", 32'h7777_7678, 1'b1, 1'b1);
  endtask

  task automatic t_64k;
    setmem(32'h0001_048C, 32'h0020_0001, 32'h0020_0130, 32'h5555_0C11);
    walk(32'h1234_C678, 2'd1, 1'b0);
    expect_ok("R8 64K quarter 3 AP", 32'h5555_C678, 1'b1, 1'b1);
    chk("R7 64K l2 address", last_addr, 32'h0020_0130);
    m_a2 = 32'h0020_0100;
    walk(32'h1234_0678, 2'd0, 1'b0);
    expect_fault("R8 64K quarter 0 AP", 8'h0F);
  endtask

  task automatic t_1k;
    setmem(32'h0001_048C, 32'h0030_0003, 32'h0030_0114, 32'h9999_9C13);
    walk(32'h1234_5678, 2'd1, 1'b1);
    expect_ok("R7 1K page pa", 32'h9999_9E78, 1'b1, 1'b1);
    walk(32'h1234_5678, 2'd0, 1'b0);
    expect_fault("R8 1K AP field", 8'h0F);
    setmem(32'h0001_048C, 32'h0020_0001, 32'h0020_0114, 32'h9999_9C13);
    walk(32'h1234_5678, 2'd2, 1'b0);
    expect_fault("R7 1K under kind 1 code 7", 8'h07);
    chk("R11 fetch fault ifsr", {24'd0, ifsr}, 32'h07);
    chk("R11 fetch fault ifar", ifar, 32'h1234_5678);
    m_d2 = 32'h9999_9C10;
    walk(32'h1234_5678, 2'd0, 1'b1);
    expect_fault("R7 l2 kind 0 code 7", 8'h07);
    chk("R11 data fault dfsr", {24'd0, dfsr}, 32'h07);
  endtask

  task automatic t_ap_rules;
    setmem(32'h0001_048C, 32'hABC0_0002, 32'h0, 32'h0);
    cfg_ctrl = 32'h101;
    walk(32'h1234_5678, 2'd0, 1'b1);
    expect_ok("R9 AP0 policy 1 priv read", 32'hABC4_5678, 1'b1, 1'b0);
    walk(32'h1234_5678, 2'd0, 1'b0);
    expect_fault("R10 AP0 policy 1 user code 13", 8'h0D);
    cfg_ctrl = 32'h201;
    walk(32'h1234_5678, 2'd2, 1'b0);
    expect_ok("R9 AP0 policy 2 user fetch", 32'hABC4_5678, 1'b1, 1'b0);
    walk(32'h1234_5678, 2'd1, 1'b1);
    expect_fault("R9 AP0 refuses write", 8'h0D);
    cfg_ctrl = 32'h301;
    walk(32'h1234_5678, 2'd0, 1'b1);
    expect_fault("R9 AP0 policy 3 no access", 8'h0D);
    cfg_ctrl = 32'h001;
    m_d1 = 32'hABC0_0022;
    walk(32'h1234_5678, 2'd1, 1'b0);
    expect_ok("R9 field 3 bypasses AP", 32'hABC4_5678, 1'b1, 1'b1);
    m_d1 = 32'hABC0_0482;
    walk(32'h1234_5678, 2'd0, 1'b0);
    expect_fault("R10 AP1 user domain 4", 8'h4D);
    walk(32'h1234_5678, 2'd1, 1'b1);
    expect_ok("R6 section AP field", 32'hABC4_5678, 1'b1, 1'b1);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_acc = '0; req_priv = 1'b0;
    cfg_ctrl = '0; cfg_ttb = 32'h0001_0000; cfg_pid = '0;
    cfg_dacr = 32'h0000_018D;
    m_a1 = '1; m_d1 = '0; m_a2 = '1; m_d2 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_mmu_off;
    t_section;
    t_reloc_on;
    t_l1_faults;
    t_4k;
    t_64k;
    t_1k;
    t_ap_rules;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule